// File: doc/BRIEF.md
# Boot Mode Reset Controller

This block supervises a microcontroller's reset line and its mode-select strap pins. It runs from a slow clock and takes a power-on reset, a reset pushbutton, a boot pushbutton and an active-low clear-to-send request line, all already synchronised to that clock. From these it decides whether the attached device should start in its normal user mode or in its boot (reprogramming) mode. It holds the device in reset for a timed period, and during a boot reset it drives a fixed mode pattern onto the strap pins through tri-state-enabled drivers.

Four states make up the controller, in two pairs. The user pair holds reset and then lets the device run. The boot pair holds reset while presenting the boot pattern, and then waits. A single retriggerable timer measures every reset period. Holding either pushbutton during a reset restarts that timer. A boot press or a falling edge on the request line swaps the mode, but only while no reset is in progress. A status line and an LED report when the controller is in a boot state.

Top module: `boot_rst_ctrl`

## Requirements
- R1: While `por_n` is low the controller is in user-reset: reset asserted, `mode_oe_o`=0, `mode_drv_o`=0, `boot_led_o`=0, `rts_o`=0.
- R2: A reset period lasts exactly TICKS clock edges counted from entry into a reset state, or from the last edge at which a restart was seen. After a user reset the controller enters user-running and deasserts reset.
- R3: When `rst_btn_i` or `boot_btn_i` is high at a clock edge during a reset state, the timer restarts. Reset then ends TICKS edges after the last such edge.
- R4: In user-running, a rising edge of `boot_btn_i` or a falling edge of `cts_n_i` moves the controller to boot-reset at the next edge.
- R5: In boot-reset only, `mode_oe_o`=1 and `mode_drv_o`=BOOT_PATTERN (default 4'b0010) for the whole reset period. In every other state `mode_oe_o`=0 and `mode_drv_o`=0.
- R6: Boot or CTS events that arrive during a user reset period are ignored: the controller never goes from user-reset to a boot state.
- R7: In boot-waiting, a rising edge of `boot_btn_i` or a falling edge of `cts_n_i` moves the controller to user-reset.
- R8: `rst_btn_i` high at a clock edge puts the controller in user-reset from any state.
- R9: `rts_o` and `boot_led_o` are 1 in boot-reset and boot-waiting, and 0 in the user states.
- R10: A CTS request is detected on its falling edge only, so holding `cts_n_i` low causes exactly one mode swap.
- R11: With RST_ACTIVE_LOW=1, `dev_rst_o` is low while reset is asserted. With the default value 0 it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow supervisory clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_btn_i | input | 1 | Reset pushbutton, high when pressed |
| boot_btn_i | input | 1 | Boot pushbutton, high when pressed |
| cts_n_i | input | 1 | Mode-swap request line, active low |
| dev_rst_o | output | 1 | Device reset, polarity set by RST_ACTIVE_LOW |
| mode_oe_o | output | 1 | Output enable for the mode-pin drivers |
| mode_drv_o | output | MODE_W | Value driven onto the mode pins when enabled |
| boot_led_o | output | 1 | Boot indicator LED |
| rts_o | output | 1 | Mode status: 1 = boot, 0 = user |

## Verification
On every cycle, the assertions check that the reset button always wins and that the counter stays within its terminal count. They also check that user-running is reached only from user-reset and boot-reset only from user-running, that user-reset cannot be left while a restart is pending, and that a CTS edge is never reported twice in a row. The exact length of each reset window, the restart of the timer by a held button, the one-swap behaviour of a held CTS line and the pattern on the strap pins are shown by the bench. It compares every output each cycle against its own state model and adds directed scenarios with explicit expected values.

// File: rtl/brc_pkg.sv
package brc_pkg;
   typedef enum logic [1:0] {
      ST_URST  = 2'd0,
      ST_URUN  = 2'd1,
      ST_BRST  = 2'd2,
      ST_BWAIT = 2'd3
   } brc_state_e;
endpackage

// File: rtl/brc_timer.sv
module brc_timer #(
   parameter int TICKS = 16384
) (
   input  logic clk,
   input  logic por_n,
   input  logic clr_i,
   input  logic run_i,
   output logic exp_o
);
   localparam int CW   = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam int LAST = TICKS - 1;

   if (TICKS < 1) begin : g_bad_ticks
      $error("brc_timer: TICKS must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                            cnt_q <= '0;
      else if (clr_i)                        cnt_q <= '0;
      else if (run_i && cnt_q != CW'(LAST))  cnt_q <= cnt_q + 1'b1;
   end

   assign exp_o = run_i && (cnt_q == CW'(LAST));

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
      cnt_q <= CW'(LAST)); // R2
endmodule

// File: rtl/brc_edge.sv
module brc_edge (
   input  logic clk,
   input  logic por_n,
   input  logic boot_i,
   input  logic cts_n_i,
   output logic boot_rise_o,
   output logic cts_fall_o
);
   logic boot_q, cts_q;

   // boot assumed pressed and cts assumed low at power-on: no false edge
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         boot_q <= 1'b1;
         cts_q  <= 1'b0;
      end else begin
         boot_q <= boot_i;
         cts_q  <= cts_n_i;
      end
   end

   assign boot_rise_o = boot_i & ~boot_q;
   assign cts_fall_o  = ~cts_n_i & cts_q;

   AST_CTS_ONCE: assert property (@(posedge clk) disable iff (!por_n)
      cts_fall_o |=> !cts_fall_o); // R10
endmodule

// File: rtl/brc_fsm.sv
module brc_fsm
   import brc_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_btn_i,
   input  logic       boot_btn_i,
   input  logic       boot_rise_i,
   input  logic       cts_fall_i,
   input  logic       tmr_exp_i,
   output brc_state_e state_o,
   output logic       tmr_clr_o,
   output logic       tmr_run_o
);
   brc_state_e st_q, st_d;
   logic       hold, swap_ev;

   assign hold    = rst_btn_i | boot_btn_i;
   assign swap_ev = boot_rise_i | cts_fall_i;

   always_comb begin
      st_d      = st_q;
      tmr_clr_o = 1'b0;
      unique case (st_q)
         ST_URST:  if (hold) tmr_clr_o = 1'b1;
                   else if (tmr_exp_i) st_d = ST_URUN;
         ST_URUN:  if (swap_ev) begin st_d = ST_BRST; tmr_clr_o = 1'b1; end
         ST_BRST:  if (hold) tmr_clr_o = 1'b1;
                   else if (tmr_exp_i) st_d = ST_BWAIT;
         ST_BWAIT: if (swap_ev) begin st_d = ST_URST; tmr_clr_o = 1'b1; end
         default:  st_d = ST_URST;
      endcase
      if (rst_btn_i) begin
         st_d      = ST_URST;
         tmr_clr_o = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) st_q <= ST_URST;
      else        st_q <= st_d;
   end

   assign state_o   = st_q;
   assign tmr_run_o = (st_q == ST_URST) || (st_q == ST_BRST);

   AST_RSTBTN_WINS: assert property (@(posedge clk) disable iff (!por_n)
      rst_btn_i |=> st_q == ST_URST); // R8
   AST_URUN_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == ST_URUN && $past(st_q) != ST_URUN) |-> $past(st_q) == ST_URST); // R2
   AST_BRST_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == ST_BRST && $past(st_q) != ST_BRST) |-> $past(st_q) == ST_URUN); // R4
   AST_IGNORE_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == ST_URST && (hold || !tmr_exp_i)) |=> st_q == ST_URST); // R6
endmodule

// File: rtl/boot_rst_ctrl.sv
module boot_rst_ctrl
   import brc_pkg::*;
#(
   parameter int              TICKS          = 16384,
   parameter int              MODE_W         = 4,
   parameter logic [MODE_W-1:0] BOOT_PATTERN = 4'b0010,
   parameter bit              RST_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_btn_i,
   input  logic              boot_btn_i,
   input  logic              cts_n_i,
   output logic              dev_rst_o,
   output logic              mode_oe_o,
   output logic [MODE_W-1:0] mode_drv_o,
   output logic              boot_led_o,
   output logic              rts_o
);
   if (MODE_W < 1 || MODE_W > 8) begin : g_bad_width
      $error("boot_rst_ctrl: MODE_W must be 1..8");
   end

   brc_state_e state;
   logic       tmr_clr, tmr_run, tmr_exp, boot_rise, cts_fall;
   logic       in_rst, in_boot;

   brc_edge u_edge (
      .clk(clk), .por_n(por_n), .boot_i(boot_btn_i), .cts_n_i(cts_n_i),
      .boot_rise_o(boot_rise), .cts_fall_o(cts_fall)
   );

   brc_timer #(.TICKS(TICKS)) u_timer (
      .clk(clk), .por_n(por_n), .clr_i(tmr_clr), .run_i(tmr_run),
      .exp_o(tmr_exp)
   );

   brc_fsm u_fsm (
      .clk(clk), .por_n(por_n), .rst_btn_i(rst_btn_i), .boot_btn_i(boot_btn_i),
      .boot_rise_i(boot_rise), .cts_fall_i(cts_fall), .tmr_exp_i(tmr_exp),
      .state_o(state), .tmr_clr_o(tmr_clr), .tmr_run_o(tmr_run)
   );

   assign in_rst  = (state == ST_URST) || (state == ST_BRST);
   assign in_boot = (state == ST_BRST) || (state == ST_BWAIT);

   if (RST_ACTIVE_LOW) begin : g_rst_low
      assign dev_rst_o = ~in_rst;
   end else begin : g_rst_high
      assign dev_rst_o = in_rst;
   end

   assign mode_oe_o  = (state == ST_BRST);
   assign mode_drv_o = mode_oe_o ? BOOT_PATTERN : '0;
   assign boot_led_o = in_boot;
   assign rts_o      = in_boot;

   AST_OE_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
      (mode_oe_o && !rst_btn_i && !boot_btn_i && !tmr_exp) |=> mode_oe_o); // R5
endmodule

// File: tb/tb_boot_rst_ctrl.sv
`timescale 1ns/100ps
module tb_boot_rst_ctrl;
   localparam int T = 6;
   localparam logic [3:0] PAT = 4'b0010;

   logic clk = 1'b0;
   logic por_n = 1'b0, rst_btn = 1'b0, boot_btn = 1'b0, cts_n = 1'b1;
   logic dev_rst, mode_oe, boot_led, rts, dev_rst_n2;
   logic [3:0] mode_drv, mode_drv2;
   logic oe2, led2, rts2;
   int   n_tests = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   boot_rst_ctrl #(.TICKS(T), .MODE_W(4), .BOOT_PATTERN(PAT), .RST_ACTIVE_LOW(1'b0)) dut (
      .clk(clk), .por_n(por_n), .rst_btn_i(rst_btn), .boot_btn_i(boot_btn),
      .cts_n_i(cts_n), .dev_rst_o(dev_rst), .mode_oe_o(mode_oe),
      .mode_drv_o(mode_drv), .boot_led_o(boot_led), .rts_o(rts));

   boot_rst_ctrl #(.TICKS(T), .MODE_W(4), .BOOT_PATTERN(PAT), .RST_ACTIVE_LOW(1'b1)) dut2 (
      .clk(clk), .por_n(por_n), .rst_btn_i(rst_btn), .boot_btn_i(boot_btn),
      .cts_n_i(cts_n), .dev_rst_o(dev_rst_n2), .mode_oe_o(oe2),
      .mode_drv_o(mode_drv2), .boot_led_o(led2), .rts_o(rts2));

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: 0 urst, 1 urun, 2 brst, 3 bwait
   int m_st = 0, m_cnt = 0;
   bit m_bq = 1'b1, m_cq = 1'b0;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_st <= 0; m_cnt <= 0; m_bq <= 1'b1; m_cq <= 1'b0;
      end else begin
         automatic bit ev = (boot_btn && !m_bq) || (!cts_n && m_cq);
         m_bq <= boot_btn;
         m_cq <= cts_n;
         if (rst_btn) begin
            m_st <= 0; m_cnt <= 0;
         end else begin
            case (m_st)
               0, 2: if (boot_btn) m_cnt <= 0;
                     else if (m_cnt == T-1) m_st <= m_st + 1;
                     else m_cnt <= m_cnt + 1;
               1: if (ev) begin m_st <= 2; m_cnt <= 0; end
               default: if (ev) begin m_st <= 0; m_cnt <= 0; end
            endcase
         end
      end
   end

   function automatic int f_rst(int s); return (s == 0 || s == 2) ? 1 : 0; endfunction
   function automatic int f_oe(int s);  return (s == 2) ? 1 : 0; endfunction
   function automatic int f_boot(int s); return (s >= 2) ? 1 : 0; endfunction

   always @(negedge clk) begin
      if (!done) begin
         chk("R2 dev_rst model", dev_rst, f_rst(m_st));
         chk("R5 mode_oe model", mode_oe, f_oe(m_st));
         chk("R5 mode_drv model", mode_drv, f_oe(m_st) ? PAT : 0);
         chk("R9 rts model", rts, f_boot(m_st));
         chk("R9 led model", boot_led, f_boot(m_st));
         chk("R11 active-low reset", dev_rst_n2, f_rst(m_st) ? 0 : 1);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      automatic int seed = $urandom(32'd4242);
      step(3);
      chk("R1 reset at power-on", dev_rst, 1);
      chk("R1 oe at power-on", mode_oe, 0);
      chk("R1 rts at power-on", rts, 0);
      chk("R1 led at power-on", boot_led, 0);
      por_n = 1'b1;
      step(T-1); chk("R2 still in reset", dev_rst, 1);
      step(1);   chk("R2 reset released", dev_rst, 0);

      // boot press from user-running
      boot_btn = 1'b1; step(1); boot_btn = 1'b0;
      chk("R4 boot reset entered", mode_oe, 1);
      chk("R5 boot pattern", mode_drv, PAT);
      step(T-1); chk("R5 pattern held to end", mode_oe, 1);
      step(1);
      chk("R5 drivers released", mode_oe, 0);
      chk("R9 rts in boot-waiting", rts, 1);
      chk("R2 boot reset ended", dev_rst, 0);

      // held CTS: one swap back to user
      cts_n = 1'b0; step(1);
      chk("R7 back to user reset", rts, 0);
      step(3*T);
      chk("R10 held cts one swap", rts, 0);
      chk("R10 running", dev_rst, 0);
      cts_n = 1'b1; step(2);

      // held reset restarts timer
      rst_btn = 1'b1; step(10); rst_btn = 1'b0;
      step(T-1); chk("R3 reset extended", dev_rst, 1);
      step(1);   chk("R3 reset ends after hold", dev_rst, 0);

      // boot press during reset ignored
      rst_btn = 1'b1; step(1); rst_btn = 1'b0; boot_btn = 1'b1; step(1); boot_btn = 1'b0;
      step(3*T);
      chk("R6 boot ignored in reset", rts, 0);
      chk("R6 no drive", mode_oe, 0);

      // reset button from boot-reset
      cts_n = 1'b0; step(1); cts_n = 1'b1;
      chk("R4 cts enters boot reset", mode_oe, 1);
      rst_btn = 1'b1; step(1); rst_btn = 1'b0;
      chk("R8 reset wins", mode_oe, 0);
      chk("R8 user mode", rts, 0);
      chk("R8 reset asserted", dev_rst, 1);

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         rst_btn  = ($urandom % 200) == 0;
         boot_btn = ($urandom % 25) == 0;
         if (($urandom % 30) == 0) cts_n = ~cts_n;
         step(1);
      end
      if (seed == 0) step(1);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule